// File: doc/BRIEF.md
# Two-Bank Packet Receive Buffer

This block buffers data arriving on a bulk OUT endpoint. It holds two banks, each one maximum packet long (64 bytes by default, 128 bytes in all). The receiver streams a packet into whichever bank is free, one byte per strobe. An end strobe closes the packet, and a good-packet flag given with that end strobe decides whether the packet is kept. A kept packet marks its bank full and records the number of bytes it holds. While the processor drains one bank, the receiver can fill the other. When both banks hold packets, the receiver sees a NAK indication until a bank is released.

The processor side always looks at the oldest full bank. It can read the bank four bytes at a time through a 32-bit word port, or one byte at a time on a DMA handshake that uses the low byte lane. It sees a full flag and the byte count of that bank. A read-done strobe hands the bank back to the receiver and moves the read side to the other bank. A clear strobe empties both banks at once.

Top module: `pingpong_rx_fifo`

## Requirements
- R1: After reset, `full_irq`, `rd_size`, `dma_req` and `rx_nak` are 0 and `rx_ready` is 1.
- R2: If `rx_end` is accepted with `rx_good` high and the read side was empty, `full_irq` is 1 in the next cycle and `rd_size` equals the number of bytes accepted for that packet. A byte given in the same cycle as `rx_end` counts.
- R3: A packet that ends with `rx_good` low is discarded. `full_irq` stays 0 and the bank stays free for the next packet, which is then read back unchanged.
- R4: `rd_word` bits 8i+7..8i hold the byte at read offset p+i, where p is the current offset and offset 0 is the first byte received. A `rd_word_stb` pulse advances p by 4.
- R5: `dma_byte` is the byte at the current offset. `dma_req` is 1 while the read bank is full and the offset is below `rd_size`. A `dma_ack` pulse advances the offset by 1, and `dma_req` drops once the last byte has been taken.
- R6: When `rd_done` arrives and the other bank also holds a packet, `full_irq` stays 1 and `rd_size` shows the count of that packet. Otherwise `full_irq` clears.
- R7: While both banks are full, `rx_nak` is 1 and `rx_ready` is 0. A packet sent in that state is ignored and never appears on the read side.
- R8: Bytes beyond 64 (PKT_BYTES) in one packet are dropped. The count stops at 64, and the first 64 bytes are kept.
- R9: `fifo_clr` empties both banks and discards a packet still being received. In the next cycle `full_irq` and `dma_req` are 0 and `rx_ready` is 1.
- R10: `rd_done` while `full_irq` is 0 has no effect. A following packet is received and read normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte_vld | input | 1 | Byte strobe from the receiver |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Packet end strobe |
| rx_good | input | 1 | Packet accepted flag, sampled with rx_end |
| rx_ready | output | 1 | A bank is free to receive |
| rx_nak | output | 1 | Both banks full; packet would be refused |
| rd_word_stb | input | 1 | Word read strobe, advances offset by 4 |
| rd_word | output | 32 | Four bytes from the current offset, little-endian |
| dma_req | output | 1 | Unread bytes remain in the read bank |
| dma_ack | input | 1 | DMA byte taken, advances offset by 1 |
| dma_byte | output | 8 | Byte at the current offset |
| rd_size | output | 7 | Byte count of the read bank (0 when empty) |
| full_irq | output | 1 | Read bank holds a packet |
| rd_done | input | 1 | Release the read bank |
| fifo_clr | input | 1 | Empty both banks |

## Verification
The bench builds the block with its default parameters: 64-byte banks and a four-byte word port. With these values a 70-byte packet tests the count limit, and a 64-byte packet read in sixteen word reads fills a bank exactly and tests the offset wrap. With only two banks, three back-to-back packets are enough to reach the NAK state, check the hand-over from one bank to the other on read-done, and show that the refused third packet never reaches the read side.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;
   typedef logic bank_sel_t;

   function automatic bank_sel_t other_bank(input bank_sel_t b);
      return ~b;
   endfunction
endpackage

// File: rtl/pp_rx_store.sv
module pp_rx_store #(
   parameter int PKT_BYTES = 64,
   parameter int LANES     = 4,
   localparam int AW       = $clog2(PKT_BYTES)
) (
   input  logic               clk,
   input  logic               we,
   input  logic               wbank,
   input  logic [AW-1:0]      waddr,
   input  logic [7:0]         wdata,
   input  logic               rbank,
   input  logic [AW-1:0]      rptr,
   output logic [8*LANES-1:0] rword
);
   localparam int DEPTH = 2 * PKT_BYTES;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[{wbank, waddr}] <= wdata;
   end

   // one read lane per byte of the word port; offsets wrap inside the bank
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [AW-1:0] off;
      assign off = rptr + AW'(i);
      assign rword[8*i +: 8] = mem[{rbank, off}];
   end
endmodule

// File: rtl/pp_rx_fill.sv
module pp_rx_fill #(
   parameter int PKT_BYTES = 64,
   localparam int AW       = $clog2(PKT_BYTES),
   localparam int CW       = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          vld,
   input  logic          end_i,
   input  logic          good,
   input  logic          blocked,
   output logic          wr_bank,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic          commit,
   output logic [CW-1:0] commit_cnt
);
   import pp_rx_pkg::*;

   logic [CW-1:0] wcnt;
   logic          take;
   logic          drop;

   assign take       = vld && !blocked && (wcnt < CW'(PKT_BYTES));
   assign we         = take && !clr;
   assign waddr      = wcnt[AW-1:0];
   assign commit     = end_i && good && !blocked && !clr;
   assign drop       = end_i && !good && !blocked;
   assign commit_cnt = wcnt + CW'(take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bank <= 1'b0;
         wcnt    <= '0;
      end else if (clr) begin
         wr_bank <= 1'b0;
         wcnt    <= '0;
      end else if (commit) begin
         wr_bank <= other_bank(wr_bank);
         wcnt    <= '0;
      end else if (drop) begin
         wcnt    <= '0;
      end else if (take) begin
         wcnt    <= wcnt + 1'b1;
      end
   end

   assert_fill_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= CW'(PKT_BYTES));

   assert_drop_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drop && !clr |=> wcnt == '0 && $stable(wr_bank));
endmodule

// File: rtl/pp_rx_drain.sv
module pp_rx_drain #(
   parameter int PKT_BYTES = 64,
   parameter int LANES     = 4,
   localparam int AW       = $clog2(PKT_BYTES),
   localparam int CW       = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          cur_full,
   input  logic [CW-1:0] cur_cnt,
   input  logic          word_stb,
   input  logic          dma_ack,
   input  logic          done,
   output logic          rd_bank,
   output logic [AW-1:0] rptr,
   output logic          dma_req,
   output logic          release_o
);
   import pp_rx_pkg::*;

   logic [CW-1:0] ptr;
   logic [CW:0]   step_sum;
   logic [CW-1:0] ptr_nxt;

   assign release_o = done && cur_full && !clr;
   assign dma_req   = cur_full && (ptr < cur_cnt);
   assign rptr      = ptr[AW-1:0];

   always_comb begin
      step_sum = {1'b0, ptr};
      if (word_stb)     step_sum = step_sum + (CW+1)'(LANES);
      else if (dma_ack) step_sum = step_sum + 1'b1;
      ptr_nxt = (step_sum > (CW+1)'(PKT_BYTES)) ? CW'(PKT_BYTES) : step_sum[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bank <= 1'b0;
         ptr     <= '0;
      end else if (clr) begin
         rd_bank <= 1'b0;
         ptr     <= '0;
      end else if (release_o) begin
         rd_bank <= other_bank(rd_bank);
         ptr     <= '0;
      end else if (cur_full) begin
         ptr     <= ptr_nxt;
      end
   end

   assert_dma_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && dma_ack && !word_stb && !done && !clr |=> ptr == $past(ptr) + 1'b1);

   assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cur_full && word_stb && !done && !clr && ptr == '0 |=> ptr == CW'(LANES));
endmodule

// File: rtl/pingpong_rx_fifo.sv
module pingpong_rx_fifo #(
   parameter int PKT_BYTES = 64,
   parameter int LANES     = 4,
   localparam int AW       = $clog2(PKT_BYTES),
   localparam int CW       = AW + 1,
   localparam int DW       = 8 * LANES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_byte_vld,
   input  logic [7:0]    rx_byte,
   input  logic          rx_end,
   input  logic          rx_good,
   output logic          rx_ready,
   output logic          rx_nak,
   input  logic          rd_word_stb,
   output logic [DW-1:0] rd_word,
   output logic          dma_req,
   input  logic          dma_ack,
   output logic [7:0]    dma_byte,
   output logic [CW-1:0] rd_size,
   output logic          full_irq,
   input  logic          rd_done,
   input  logic          fifo_clr
);
   if ((1 << AW) != PKT_BYTES) begin : g_bad_pkt
      $error("PKT_BYTES must be a power of two");
   end
   if (LANES < 1 || LANES > PKT_BYTES || (PKT_BYTES % LANES) != 0) begin : g_bad_lanes
      $error("LANES must divide PKT_BYTES");
   end

   logic          wr_bank, rd_bank;
   logic          we, commit, release_w;
   logic [AW-1:0] waddr, rptr;
   logic [CW-1:0] commit_cnt;
   logic [1:0]    bank_full;
   logic [CW-1:0] bank_cnt [2];
   logic          cur_full;
   logic [CW-1:0] cur_cnt;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_full[b] <= 1'b0;
            bank_cnt[b]  <= '0;
         end else if (fifo_clr) begin
            bank_full[b] <= 1'b0;
            bank_cnt[b]  <= '0;
         end else if (commit && wr_bank == 1'(b)) begin
            bank_full[b] <= 1'b1;
            bank_cnt[b]  <= commit_cnt;
         end else if (release_w && rd_bank == 1'(b)) begin
            bank_full[b] <= 1'b0;
         end
      end
   end

   assign cur_full = bank_full[rd_bank];
   assign cur_cnt  = bank_cnt[rd_bank];
   assign full_irq = cur_full;
   assign rd_size  = cur_full ? cur_cnt : '0;
   assign rx_ready = !bank_full[wr_bank];
   assign rx_nak   = &bank_full;
   assign dma_byte = rd_word[7:0];

   pp_rx_fill #(.PKT_BYTES(PKT_BYTES)) u_fill (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .vld(rx_byte_vld),
      .end_i(rx_end), .good(rx_good), .blocked(bank_full[wr_bank]),
      .wr_bank(wr_bank), .we(we), .waddr(waddr),
      .commit(commit), .commit_cnt(commit_cnt));

   pp_rx_drain #(.PKT_BYTES(PKT_BYTES), .LANES(LANES)) u_drain (
      .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .cur_full(cur_full),
      .cur_cnt(cur_cnt), .word_stb(rd_word_stb), .dma_ack(dma_ack),
      .done(rd_done), .rd_bank(rd_bank), .rptr(rptr),
      .dma_req(dma_req), .release_o(release_w));

   pp_rx_store #(.PKT_BYTES(PKT_BYTES), .LANES(LANES)) u_store (
      .clk(clk), .we(we), .wbank(wr_bank), .waddr(waddr), .wdata(rx_byte),
      .rbank(rd_bank), .rptr(rptr), .rword(rd_word));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_end && rx_good && rx_ready && !full_irq && !fifo_clr |=> full_irq);

   assert_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done && rx_nak && !fifo_clr |=> full_irq && !rx_nak);

   assert_nak_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_nak && !rd_done && !fifo_clr |=> rx_nak && !rx_ready);

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> !full_irq && !dma_req && rx_ready);

   assert_size_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_size <= CW'(PKT_BYTES));

   assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done && !full_irq && !rx_end && !fifo_clr |=> !full_irq);
endmodule

// File: tb/sim_pingpong_rx_fifo.sv
module sim_pingpong_rx_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int PKT        = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_byte_vld = 1'b0, rx_end = 1'b0, rx_good = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_ready, rx_nak, dma_req, full_irq;
   logic        rd_word_stb = 1'b0, dma_ack = 1'b0, rd_done = 1'b0, fifo_clr = 1'b0;
   logic [31:0] rd_word;
   logic [7:0]  dma_byte;
   logic [6:0]  rd_size;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;
   byte unsigned exp_q[$];
   int           cnt_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pingpong_rx_fifo u0 (
      .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
      .rx_end(rx_end), .rx_good(rx_good), .rx_ready(rx_ready), .rx_nak(rx_nak),
      .rd_word_stb(rd_word_stb), .rd_word(rd_word), .dma_req(dma_req),
      .dma_ack(dma_ack), .dma_byte(dma_byte), .rd_size(rd_size),
      .full_irq(full_irq), .rd_done(rd_done), .fifo_clr(fifo_clr));

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // driver: streams a packet and records what the read side must return
   task automatic send(int n, bit good, int seed, bit kept);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_byte_vld = 1'b1;
         rx_byte     = 8'((seed + i * 7) & 8'hff);
         rx_end      = (i == n - 1);
         rx_good     = good;
         if (kept && good && i < PKT) exp_q.push_back(rx_byte);
      end
      @(negedge clk);
      rx_byte_vld = 1'b0; rx_end = 1'b0; rx_good = 1'b0;
      if (kept && good) cnt_q.push_back((n < PKT) ? n : PKT);
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   // monitor: drains the head packet by DMA and compares against the queue
   task automatic drain_dma(string req);
      int n = cnt_q.pop_front();
      chk({req, " size"}, int'(rd_size), n);
      for (int k = 0; k < n; k++) begin
         byte unsigned b = exp_q.pop_front();
         chk("R5 dma_req high", int'(dma_req), 1);
         chk({req, " dma byte"}, int'(dma_byte), int'(b));
         pulse(dma_ack);
      end
      chk("R5 dma_req low after last", int'(dma_req), 0);
   endtask

   // monitor: drains the head packet through the word port
   task automatic drain_word(string req);
      int n = cnt_q.pop_front();
      chk({req, " size"}, int'(rd_size), n);
      for (int w = 0; w < (n + 3) / 4; w++) begin
         for (int l = 0; l < 4; l++) begin
            if (w * 4 + l < n) begin
               byte unsigned b = exp_q.pop_front();
               chk("R4 word lane", int'(rd_word[8*l +: 8]), int'(b));
            end
         end
         pulse(rd_word_stb);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 full", int'(full_irq), 0);
      chk("R1 size", int'(rd_size), 0);
      chk("R1 dma_req", int'(dma_req), 0);
      chk("R1 ready", int'(rx_ready), 1);
      chk("R1 nak", int'(rx_nak), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R5: one packet, drained by DMA
      send(10, 1'b1, 3, 1'b1);
      chk("R2 full", int'(full_irq), 1);
      drain_dma("R2");
      pulse(rd_done);
      chk("R6 full clears", int'(full_irq), 0);

      // R3: bad packet discarded, next one intact
      send(5, 1'b0, 90, 1'b0);
      chk("R3 full stays low", int'(full_irq), 0);
      chk("R3 ready", int'(rx_ready), 1);
      send(8, 1'b1, 40, 1'b1);
      drain_word("R3");
      pulse(rd_done);

      // R7 / R6: both banks full, third packet refused
      send(64, 1'b1, 11, 1'b1);
      send(3, 1'b1, 200, 1'b1);
      chk("R7 nak", int'(rx_nak), 1);
      chk("R7 ready", int'(rx_ready), 0);
      send(4, 1'b1, 150, 1'b0);
      drain_word("R4");
      pulse(rd_done);
      chk("R6 full stays", int'(full_irq), 1);
      drain_dma("R6");
      pulse(rd_done);
      chk("R7 refused packet absent", int'(full_irq), 0);

      // R10: read-done while empty
      pulse(rd_done);
      chk("R10 still empty", int'(full_irq), 0);
      send(6, 1'b1, 77, 1'b1);
      drain_dma("R10");
      pulse(rd_done);

      // R8: oversize packet
      send(70, 1'b1, 5, 1'b1);
      drain_dma("R8");
      pulse(rd_done);

      // R9: clear with one packet stored and one in flight
      send(5, 1'b1, 60, 1'b0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); rx_byte_vld = 1'b1; rx_byte = 8'(i);
      end
      @(negedge clk); rx_byte_vld = 1'b0; fifo_clr = 1'b1;
      @(negedge clk); fifo_clr = 1'b0;
      chk("R9 full", int'(full_irq), 0);
      chk("R9 dma_req", int'(dma_req), 0);
      chk("R9 ready", int'(rx_ready), 1);
      send(4, 1'b1, 130, 1'b1);
      drain_dma("R9");
      pulse(rd_done);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule